// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between a simple register bus and the shift engine of an SPI peripheral. It holds a transmit FIFO, which software fills through a data register and the shift engine drains, and a receive FIFO, which the shift engine fills and software drains through a read-to-pop data register. Each FIFO's occupancy is compared against a programmable watermark to produce a transmit-data flag and a receive-data flag.

Two event flags record per-frame and per-transfer completion pulses from the shift engine. They are cleared by writing one to them. An interrupt-enable register selects which status bits drive the single interrupt line. A DMA-enable register lets each data flag become a DMA request. Control bits enable the module, flush either FIFO, or reset every register and both FIFOs. A read-only parameter word reports both FIFO depths as log2, so driver code can size its bursts.

Register map, as word addresses on `bus_addr`:

- 0: parameters (read-only).
- 1: control.
- 2: status.
- 3: interrupt enable.
- 4: DMA enable.
- 5: watermarks.
- 6: FIFO counts.
- 7: transmit data (write-only).
- 8: receive status.
- 9: receive data (read pops).

Top module: `spi_fifo_stat`

## Requirements
- R1: The parameter register (address 0) reads the transmit FIFO depth as log2 in bits [3:0] and the receive FIFO depth as log2 in bits [11:8]. All other bits read 0.
- R2: A write to address 7 pushes the written data into the transmit FIFO. A write while the FIFO is full is ignored. The transmit count reads in bits [7:0] of address 6, and the receive count reads from bit 16 of address 6.
- R3: A `rx_push` pulse stores `rx_data` in the receive FIFO, and it is dropped when the FIFO is full. A bus read of address 9 with `bus_re` returns the oldest entry and removes it; it returns 0 when the FIFO is empty. Bit 1 of address 8 reads 1 exactly when the receive FIFO is empty.
- R4: Status bit 0 (address 2) is 1 while the transmit count is less than or equal to the transmit watermark. The transmit watermark is held in the low field of address 5.
- R5: Status bit 1 is 1 while the receive count is greater than the receive watermark. The receive watermark is held in the field starting at bit 16 of address 5.
- R6: A pulse on `eng_frame_done` sets status bit 9, and a pulse on `eng_xfer_done` sets status bit 10. Writing one to such a bit clears it, and writing zero leaves it unchanged. A completion pulse in the same cycle as the clearing write leaves the flag set.
- R7: `irq` is 1 exactly when some status bit among 0, 1, 9 and 10 is 1 and the interrupt-enable register (address 3) has the bit at the same position set.
- R8: `tx_dma_req` equals status bit 0 ANDed with DMA-enable bit 0 (address 4). `rx_dma_req` equals status bit 1 ANDed with DMA-enable bit 1.
- R9: Writing one to control bit 8 empties the transmit FIFO, and writing one to control bit 9 empties the receive FIFO. Each leaves the other FIFO untouched, and both bits read back as 0.
- R10: Writing one to control bit 1 returns both FIFOs, the event flags, the watermarks and the enable registers to their reset values. This bit reads back as 0.
- R11: Status bit 24 follows the `eng_busy` input.
- R12: `tx_valid` is 1 when control bit 0 (module enable) is set and the transmit FIFO is not empty. While `tx_valid` is 1, `tx_data` shows the oldest transmit entry, and a `tx_pop` pulse removes it. A `tx_pop` while `tx_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops receive data at address 9) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_valid | output | 1 | Transmit entry available to the shift engine |
| tx_data | output | DATA_W | Oldest transmit entry |
| tx_pop | input | 1 | Shift engine consumes the transmit entry |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_data | input | DATA_W | Received word |
| eng_frame_done | input | 1 | Frame completion pulse |
| eng_xfer_done | input | 1 | Transfer completion pulse |
| eng_busy | input | 1 | Shift engine busy level |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench builds the unit with a 16-bit data width, a four-entry transmit FIFO and an eight-entry receive FIFO. The two depths differ, so the parameter word, the count fields and the watermark fields show when the two sides are swapped. The depths are small enough that random traffic often fills and empties both FIFOs, and it crosses every watermark value from 0 to full. With 16-bit data, the upper write-data bits must be dropped on push, and received words must read back zero-extended.

// File: rtl/sfs_pkg.sv
`timescale 1ns/1ps
// Package: register word addresses and bit positions shared by the
// SPI FIFO status unit and its sub-blocks.
package sfs_pkg;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned BUS_W  = 32;

    localparam logic [ADDR_W-1:0] A_PARAM = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'd3;
    localparam logic [ADDR_W-1:0] A_DMAEN = 4'd4;
    localparam logic [ADDR_W-1:0] A_WMARK = 4'd5;
    localparam logic [ADDR_W-1:0] A_CNT   = 4'd6;
    localparam logic [ADDR_W-1:0] A_TXD   = 4'd7;
    localparam logic [ADDR_W-1:0] A_RXST  = 4'd8;
    localparam logic [ADDR_W-1:0] A_RXD   = 4'd9;

    // status / interrupt-enable bit positions
    localparam int unsigned S_TXD  = 0;
    localparam int unsigned S_RXD  = 1;
    localparam int unsigned S_FRM  = 9;
    localparam int unsigned S_XFR  = 10;
    localparam int unsigned S_BUSY = 24;

    // control bit positions
    localparam int unsigned C_EN   = 0;
    localparam int unsigned C_SRST = 1;
    localparam int unsigned C_FTX  = 8;
    localparam int unsigned C_FRX  = 9;

    // field offset of the receive-side value in count and watermark words
    localparam int unsigned RX_FIELD = 16;
endpackage

// File: rtl/sfs_fifo.sv
`timescale 1ns/1ps
// Module: sfs_fifo
// Synchronous FIFO with occupancy count. Depth is 2**LOG2.
// Assumes: push when full and pop when empty are dropped; clr empties the
// FIFO and wins over push/pop in the same cycle; rdata is only meaningful
// while empty is low.
module sfs_fifo #(
    parameter int unsigned W    = 32,
    parameter int unsigned LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            push,
    input  logic [W-1:0]    wdata,
    input  logic            pop,
    output logic [W-1:0]    rdata,
    output logic [LOG2:0]   count,
    output logic            full,
    output logic            empty
);
    localparam int unsigned DEPTH = 1 << LOG2;

    logic [W-1:0]    mem [DEPTH];
    logic [LOG2-1:0] wr_ptr;
    logic [LOG2-1:0] rd_ptr;
    logic            push_ok;
    logic            pop_ok;

    assign full    = (count == (LOG2+1)'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Pointer and count update, with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= wdata;
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (LOG2+1)'(DEPTH));
    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> $stable(count));
    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/sfs_flags.sv
`timescale 1ns/1ps
// Module: sfs_flags
// Builds the status word from FIFO counts, watermarks and engine pulses,
// holds the interrupt-enable and DMA-enable registers, and drives the
// interrupt and DMA request lines.
// Assumes: w1c/ien/dma write strobes come pre-decoded from the register
// bus; srst is a one-cycle soft reset strobe.
module sfs_flags
    import sfs_pkg::*;
#(
    parameter int unsigned TXC_W = 3,
    parameter int unsigned RXC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic [TXC_W-1:0] tx_cnt,
    input  logic [TXC_W-1:0] tx_wm,
    input  logic [RXC_W-1:0] rx_cnt,
    input  logic [RXC_W-1:0] rx_wm,
    input  logic             frame_pulse,
    input  logic             xfer_pulse,
    input  logic             busy,
    input  logic             stat_wr,
    input  logic [1:0]       stat_w1c,  // {xfer, frame}
    input  logic             ien_wr,
    input  logic [3:0]       ien_wdata, // {xfer, frame, rxd, txd}
    input  logic             dma_wr,
    input  logic [1:0]       dma_wdata, // {rx, tx}
    output logic [BUS_W-1:0] stat,
    output logic [3:0]       ien_q,
    output logic [1:0]       dma_q,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);
    logic ev_frm;
    logic ev_xfr;
    logic txd;
    logic rxd;

    assign txd = (tx_cnt <= tx_wm);
    assign rxd = (rx_cnt >  rx_wm);

    // Completion event flags: set by pulse, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ev_frm <= 1'b0;
            ev_xfr <= 1'b0;
        end else begin
            ev_frm <= frame_pulse || (ev_frm && !(stat_wr && stat_w1c[0]));
            ev_xfr <= xfer_pulse  || (ev_xfr && !(stat_wr && stat_w1c[1]));
        end
    end

    // Interrupt-enable and DMA-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ien_q <= '0;
            dma_q <= '0;
        end else begin
            if (ien_wr) ien_q <= ien_wdata;
            if (dma_wr) dma_q <= dma_wdata;
        end
    end

    // Status word assembly.
    always_comb begin
        stat         = '0;
        stat[S_TXD]  = txd;
        stat[S_RXD]  = rxd;
        stat[S_FRM]  = ev_frm;
        stat[S_XFR]  = ev_xfr;
        stat[S_BUSY] = busy;
    end

    assign irq = (txd && ien_q[0]) || (rxd && ien_q[1]) ||
                 (ev_frm && ien_q[2]) || (ev_xfr && ien_q[3]);
    assign tx_dma_req = txd && dma_q[0];
    assign rx_dma_req = rxd && dma_q[1];

    assert_event_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && !srst) |=> stat[S_FRM]);
    assert_irq_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_pulse && ien_q[3] && !ien_wr && !srst) |=> irq);
    assert_txdma_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt > tx_wm) |-> !tx_dma_req);
    assert_rxdma_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt <= rx_wm) |-> !rx_dma_req);
endmodule

// File: rtl/spi_fifo_stat.sv
`timescale 1ns/1ps
// Module: spi_fifo_stat
// FIFO, status, interrupt and DMA-request unit of an SPI peripheral.
// Decodes the register bus, owns the control and watermark registers,
// and connects two FIFOs to the status/interrupt block.
// Assumes: single-cycle register bus, read data combinational on bus_addr;
// TX_LOG2 and RX_LOG2 are at most 7 so counts fit their 8-bit fields.
module spi_fifo_stat
    import sfs_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TX_LOG2 = 2,
    parameter int unsigned RX_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              eng_frame_done,
    input  logic              eng_xfer_done,
    input  logic              eng_busy,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);
    localparam int unsigned TXC_W = TX_LOG2 + 1;
    localparam int unsigned RXC_W = RX_LOG2 + 1;

    logic              wr_ctrl;
    logic              srst;
    logic              tx_clr;
    logic              rx_clr;
    logic              en_q;
    logic [TXC_W-1:0]  tx_wm;
    logic [RXC_W-1:0]  rx_wm;
    logic [TXC_W-1:0]  tx_cnt;
    logic [RXC_W-1:0]  rx_cnt;
    logic              tx_full;
    logic              tx_empty;
    logic              rx_full;
    logic              rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              rx_pop;
    logic [BUS_W-1:0]  stat;
    logic [3:0]        ien_q;
    logic [1:0]        dma_q;

    assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
    assign srst     = wr_ctrl && bus_wdata[C_SRST];
    assign tx_clr   = srst || (wr_ctrl && bus_wdata[C_FTX]);
    assign rx_clr   = srst || (wr_ctrl && bus_wdata[C_FRX]);
    assign rx_pop   = bus_re && (bus_addr == A_RXD);
    assign tx_valid = en_q && !tx_empty;

    // Module enable and watermark registers.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            en_q  <= 1'b0;
            tx_wm <= '0;
            rx_wm <= '0;
        end else begin
            if (wr_ctrl) en_q <= bus_wdata[C_EN];
            if (bus_we && (bus_addr == A_WMARK)) begin
                tx_wm <= bus_wdata[TXC_W-1:0];
                rx_wm <= bus_wdata[RX_FIELD +: RXC_W];
            end
        end
    end

    sfs_fifo #(.W(DATA_W), .LOG2(TX_LOG2)) u_txf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (bus_we && (bus_addr == A_TXD)),
        .wdata (bus_wdata[DATA_W-1:0]),
        .pop   (tx_pop && tx_valid),
        .rdata (tx_data),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sfs_fifo #(.W(DATA_W), .LOG2(RX_LOG2)) u_rxf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .wdata (rx_data),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    sfs_flags #(.TXC_W(TXC_W), .RXC_W(RXC_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst        (srst),
        .tx_cnt      (tx_cnt),
        .tx_wm       (tx_wm),
        .rx_cnt      (rx_cnt),
        .rx_wm       (rx_wm),
        .frame_pulse (eng_frame_done),
        .xfer_pulse  (eng_xfer_done),
        .busy        (eng_busy),
        .stat_wr     (bus_we && (bus_addr == A_STAT)),
        .stat_w1c    ({bus_wdata[S_XFR], bus_wdata[S_FRM]}),
        .ien_wr      (bus_we && (bus_addr == A_IEN)),
        .ien_wdata   ({bus_wdata[S_XFR], bus_wdata[S_FRM], bus_wdata[S_RXD], bus_wdata[S_TXD]}),
        .dma_wr      (bus_we && (bus_addr == A_DMAEN)),
        .dma_wdata   (bus_wdata[1:0]),
        .stat        (stat),
        .ien_q       (ien_q),
        .dma_q       (dma_q),
        .irq         (irq),
        .tx_dma_req  (tx_dma_req),
        .rx_dma_req  (rx_dma_req)
    );

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_PARAM: begin
                bus_rdata[3:0]  = 4'(TX_LOG2);
                bus_rdata[11:8] = 4'(RX_LOG2);
            end
            A_CTRL:  bus_rdata[C_EN] = en_q;
            A_STAT:  bus_rdata = stat;
            A_IEN: begin
                bus_rdata[S_TXD] = ien_q[0];
                bus_rdata[S_RXD] = ien_q[1];
                bus_rdata[S_FRM] = ien_q[2];
                bus_rdata[S_XFR] = ien_q[3];
            end
            A_DMAEN: bus_rdata[1:0] = dma_q;
            A_WMARK: begin
                bus_rdata[TXC_W-1:0]          = tx_wm;
                bus_rdata[RX_FIELD +: RXC_W]  = rx_wm;
            end
            A_CNT: begin
                bus_rdata[TXC_W-1:0]          = tx_cnt;
                bus_rdata[RX_FIELD +: RXC_W]  = rx_cnt;
            end
            A_RXST:  bus_rdata[1] = rx_empty;
            A_RXD:   bus_rdata[DATA_W-1:0] = rx_empty ? '0 : rx_head;
            default: bus_rdata = '0;
        endcase
    end

    assert_tx_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[C_FTX]) |=> (tx_cnt == '0));
    assert_rx_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[C_FRX]) |=> (rx_cnt == '0));
    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!en_q && ien_q == '0 && tx_empty && rx_empty));
    assert_txv_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && en_q) |-> tx_valid);
    assert_rxfull_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> (rx_cnt == RXC_W'(1 << RX_LOG2)));
endmodule

// File: tb/tb_spi_fifo_stat.sv
`timescale 1ns/1ps
// Bench for spi_fifo_stat: directed corner cases followed by seeded random
// traffic, checked against a queue-based model built from the requirements.
module tb_spi_fifo_stat;
    localparam int DW = 16;
    localparam int TXL = 2;
    localparam int RXL = 3;
    localparam int TXD = 1 << TXL;
    localparam int RXD = 1 << RXL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          tx_valid;
    logic [DW-1:0] tx_data;
    logic          tx_pop = 1'b0;
    logic          rx_push = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          eng_frame_done = 1'b0;
    logic          eng_xfer_done = 1'b0;
    logic          eng_busy = 1'b0;
    logic          irq;
    logic          tx_dma_req;
    logic          rx_dma_req;

    spi_fifo_stat #(.DATA_W(DW), .TX_LOG2(TXL), .RX_LOG2(RXL)) dut (.*);

    always #5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    // model state
    int tq[$];
    int rq[$];
    int twm = 0;
    int rwm = 0;
    bit ev_f = 0;
    bit ev_x = 0;
    bit [3:0] ien = '0;
    bit [1:0] dmae = '0;
    bit en = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s = '0;
        s[0]  = (tq.size() <= twm);
        s[1]  = (rq.size() > rwm);
        s[9]  = ev_f;
        s[10] = ev_x;
        s[24] = eng_busy;
        return s;
    endfunction

    function automatic logic exp_irq();
        logic [31:0] s = exp_stat();
        return (s[0] & ien[0]) | (s[1] & ien[1]) | (s[9] & ien[2]) | (s[10] & ien[3]);
    endfunction

    function automatic logic [31:0] exp_cnt();
        return 32'(tq.size()) | (32'(rq.size()) << 16);
    endfunction

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic eng(bit pop, bit push, logic [DW-1:0] d, bit frm, bit xfr);
        @(negedge clk);
        tx_pop = pop; rx_push = push; rx_data = d;
        eng_frame_done = frm; eng_xfer_done = xfr;
        @(posedge clk); #1;
        tx_pop = 0; rx_push = 0; eng_frame_done = 0; eng_xfer_done = 0;
    endtask

    task automatic model_txpush(logic [31:0] d);
        if (tq.size() < TXD) tq.push_back(int'(d[DW-1:0]));
    endtask

    task automatic model_rxpush(logic [DW-1:0] d);
        if (rq.size() < RXD) rq.push_back(int'(d));
    endtask

    task automatic check_all(string ctx);
        logic [31:0] d;
        rd(4'd6, d);  chk({"R2 counts ", ctx}, d, exp_cnt());
        rd(4'd2, d);  chk({"R4/R5/R6 status ", ctx}, d, exp_stat());
        #1;
        chk({"R7 irq ", ctx}, 32'(irq), 32'(exp_irq()));
        chk({"R8 tx dma ", ctx}, 32'(tx_dma_req), 32'(exp_stat() & 1 & dmae[0]));
        chk({"R8 rx dma ", ctx}, 32'(rx_dma_req), 32'(exp_stat() >> 1 & 1 & dmae[1]));
        chk({"R12 tx_valid ", ctx}, 32'(tx_valid), 32'(en && tq.size() > 0));
        if (en && tq.size() > 0) chk({"R12 tx_data ", ctx}, 32'(tx_data), 32'(tq[0]));
        rd(4'd8, d);  chk({"R3 rx empty ", ctx}, d, (rq.size() == 0) ? 32'h2 : 32'h0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        check_all("after reset");
        rd(4'd0, d); chk("R1 param", d, 32'h0000_0302);
        rd(4'd1, d); chk("R10 ctrl reset", d, 32'h0);

        // R2: fill past full, extra write dropped; R12 order through engine
        wr(4'd1, 32'h1); en = 1;
        for (int i = 0; i < TXD + 1; i++) begin
            d = 32'hABCD_0000 | 32'(i + 1);
            wr(4'd7, d); model_txpush(d);
        end
        check_all("tx full");
        for (int i = 0; i < TXD; i++) begin
            #1 chk("R12 tx order", 32'(tx_data), 32'(i + 1));
            eng(1, 0, '0, 0, 0); void'(tq.pop_front());
        end
        eng(1, 0, '0, 0, 0);
        check_all("tx drained, extra pop");

        // R12: disabled module hides data and ignores pop
        wr(4'd7, 32'h55); model_txpush(32'h55);
        wr(4'd1, 32'h0); en = 0;
        eng(1, 0, '0, 0, 0);
        check_all("pop while disabled");

        // R3: fill receive past full, read back zero-extended in order
        for (int i = 0; i < RXD + 1; i++) begin
            eng(0, 1, DW'(16'hF000 + i), 0, 0); model_rxpush(DW'(16'hF000 + i));
        end
        check_all("rx full");
        rd(4'd9, d); chk("R3 rx head", d, 32'(rq.pop_front()));

        // R9: flush tx only, both bits read 0
        wr(4'd1, 32'h100); tq.delete(); en = 0;
        check_all("tx flush");
        rd(4'd1, d); chk("R9 ctrl readback", d, 32'h0);
        // R9: flush rx only, tx untouched
        wr(4'd7, 32'h77); model_txpush(32'h77);
        wr(4'd1, 32'h201); rq.delete(); en = 1;
        check_all("rx flush");
        rd(4'd9, d); chk("R3 rx read empty", d, 32'h0);

        // R6: set, write-zero keeps, write-one clears, set wins
        eng(0, 0, '0, 1, 1); ev_f = 1; ev_x = 1;
        wr(4'd2, 32'h0);
        check_all("w1c zero");
        wr(4'd2, 32'h200); ev_f = 0;
        check_all("w1c frame");
        @(negedge clk);
        bus_addr = 4'd2; bus_wdata = 32'h400; bus_we = 1; eng_xfer_done = 1;
        @(posedge clk); #1 bus_we = 0; eng_xfer_done = 0;
        check_all("set wins R6");

        // R11 busy
        eng_busy = 1;
        check_all("busy R11");
        eng_busy = 0;

        // R10 soft reset after loading everything
        wr(4'd3, 32'hFFFF_FFFF); ien = 4'hF;
        wr(4'd4, 32'h3); dmae = 2'h3;
        wr(4'd5, 32'h0005_0003); twm = 3; rwm = 5;
        eng(0, 1, DW'(16'h1234), 1, 0); model_rxpush(DW'(16'h1234)); ev_f = 1;
        check_all("loaded");
        wr(4'd1, 32'h3);
        tq.delete(); rq.delete(); ien = 0; dmae = 0; twm = 0; rwm = 0;
        ev_f = 0; ev_x = 0; en = 0;
        check_all("soft reset R10");
        rd(4'd3, d); chk("R10 ien cleared", d, 32'h0);
        rd(4'd5, d); chk("R10 wmark cleared", d, 32'h0);
        rd(4'd1, d); chk("R10 ctrl readback", d, 32'h0);

        // random traffic
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom_range(0, 7));
            logic [31:0] r = $urandom();
            case (op)
                0: begin wr(4'd7, r); model_txpush(r); end
                1: begin
                    eng(1, 0, '0, 0, 0);
                    if (en && tq.size() > 0) void'(tq.pop_front());
                end
                2: begin eng(0, 1, r[DW-1:0], 0, 0); model_rxpush(r[DW-1:0]); end
                3: begin
                    logic [31:0] e = (rq.size() > 0) ? 32'(rq.pop_front()) : 32'h0;
                    rd(4'd9, d); chk("R3 random rx read", d, e);
                end
                4: begin
                    twm = int'($urandom_range(0, TXD));
                    rwm = int'($urandom_range(0, RXD));
                    wr(4'd5, 32'(twm) | (32'(rwm) << 16));
                end
                5: begin
                    eng(0, 0, '0, r[0], r[1]);
                    if (r[0]) ev_f = 1;
                    if (r[1]) ev_x = 1;
                end
                6: begin
                    wr(4'd2, r);
                    if (r[9]) ev_f = 0;
                    if (r[10]) ev_x = 0;
                end
                default: begin
                    wr(4'd3, r); ien = {r[10], r[9], r[1], r[0]};
                    wr(4'd4, r >> 4); dmae = r[5:4];
                    wr(4'd1, {31'h0, r[7]}); en = r[7];
                end
            endcase
            check_all("random");
        end

        finished = 1;
        summary();
    end
endmodule